// File: doc/BRIEF.md
# Six-Channel Pulse-Width Modulator with Double-Buffered Commit

This block produces six independent pulse-width modulated outputs, each set up through a small register window on a 32-bit memory-mapped bus. For each channel, software writes a period length and an active-phase length, both counted in input clock cycles. These values go into staging registers. They do not change the running waveform until software asks for a commit, which it does by taking a control bit from 0 to 1. The commit then takes effect at the next period boundary, so a changed setting never cuts a period short or stretches it.

Writing a self-clearing launch bit starts a channel, and the channel then runs continuously. A per-channel polarity bit chooses whether the active phase drives the pin high or low. To stop a running channel, software commits an active phase of zero. The pin then stays at its inactive level for whole periods. A committed period of zero is treated as invalid, and the pin stays inactive.

Top module: `pwm6_bank`

## Requirements
- R1: After reset, every stored register reads 0, no channel runs, and every output is high (the inactive level for polarity bit 0).
- R2: Channel n has its register window at byte address n*0x20. Control is at offset 0x00, staged period at 0x08 and staged active phase at 0x0C. Reading the period and active-phase offsets returns the staged values.
- R3: In the control register, bits 2 (commit request), 5 (continuous), 8 (polarity) and 9 (output enable) are stored and read back. Bit 0 (launch) always reads 0, and every other bit reads 0.
- R4: The staged period and active phase reach the running counter only after a write takes control bit 2 from 0 to 1. Writing bit 2 as 1 while it already holds 1 changes nothing.
- R5: Writing 1 to control bit 0 launches the channel into continuous output. A channel that has committed values but has not been launched keeps its output inactive.
- R6: A running channel with committed period P and active phase D (0 < D < P) repeats every P cycles and is active for D cycles of each period. With bit 8 = 1 the active level is high; with bit 8 = 0 it is low. The inactive level is the opposite one.
- R7: While the committed period is 0, the output stays at its inactive level.
- R8: A committed active phase of 0 holds the output at its inactive level for whole periods.
- R9: A committed active phase greater than or equal to the period holds the output active for the entire period.
- R10: A commit made while a channel runs takes effect only at the end of the period in progress. Every period on the output is a complete period of either the old setting or the new one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all counts are in its cycles |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte address: channel index in bits 7:5, register offset in bits 4:0 |
| bus_we | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pwm_out | output | 6 | One modulated output per channel |

## Verification
The hardest case to reach is a commit that lands in the middle of a running period. The bench waits for a rising output edge on a channel with a long setting. It then issues the staging and commit writes in a parallel thread while a second thread measures the length of every high run. Only the old and new active lengths may appear. The other hard case is the ignored repeat request (bit 2 written as 1 while it already holds 1). It is covered by changing a staged value, measuring the active time that follows, and then clearing and re-setting the bit to show that the same staged value does take effect.

// File: rtl/pwm6_pkg.sv
package pwm6_pkg;
  localparam int unsigned WORD_W   = 32;
  localparam int unsigned OFF_W    = 5;
  localparam logic [OFF_W-1:0] OFF_CTRL = 5'h00;
  localparam logic [OFF_W-1:0] OFF_PER  = 5'h08;
  localparam logic [OFF_W-1:0] OFF_ACT  = 5'h0C;

  localparam int unsigned B_LAUNCH = 0;
  localparam int unsigned B_COMMIT = 2;
  localparam int unsigned B_CONT   = 5;
  localparam int unsigned B_POL    = 8;
  localparam int unsigned B_OE     = 9;

  localparam logic [WORD_W-1:0] CTRL_KEEP =
    (32'd1 << B_COMMIT) | (32'd1 << B_CONT) | (32'd1 << B_POL) | (32'd1 << B_OE);

  function automatic logic [WORD_W-1:0] next_count(input logic [WORD_W-1:0] cnt,
                                                    input logic [WORD_W-1:0] per);
    return (cnt == per - 1) ? '0 : cnt + 1;
  endfunction

  function automatic logic in_active_phase(input logic [WORD_W-1:0] cnt,
                                           input logic [WORD_W-1:0] act);
    return cnt < act;
  endfunction

  function automatic logic pin_level(input logic active, input logic pol);
    return pol ? active : !active;
  endfunction
endpackage

// File: rtl/pwm6_chan_regs.sv
module pwm6_chan_regs
  import pwm6_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ctrl,
  input  logic              wr_per,
  input  logic              wr_act,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] ctrl_q,
  output logic [WORD_W-1:0] stg_per,
  output logic [WORD_W-1:0] stg_act,
  output logic              launch_pulse,
  output logic              commit_rise
);
  assign launch_pulse = wr_ctrl && wdata[B_LAUNCH];
  assign commit_rise  = wr_ctrl && wdata[B_COMMIT] && !ctrl_q[B_COMMIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      stg_per <= '0;
      stg_act <= '0;
    end else begin
      if (wr_ctrl) ctrl_q  <= wdata & CTRL_KEEP;
      if (wr_per)  stg_per <= wdata;
      if (wr_act)  stg_act <= wdata;
    end
  end
endmodule

// File: rtl/pwm6_chan_core.sv
module pwm6_chan_core
  import pwm6_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch_pulse,
  input  logic              commit_rise,
  input  logic [WORD_W-1:0] stg_per,
  input  logic [WORD_W-1:0] stg_act,
  input  logic              pol,
  output logic              pin,
  output logic              running,
  output logic              pending,
  output logic [WORD_W-1:0] act_per,
  output logic [WORD_W-1:0] act_duty,
  output logic [WORD_W-1:0] cnt
);
  logic at_boundary;
  logic apply_now;
  logic active;

  // a period boundary exists at the last count, or any time nothing is counting
  assign at_boundary = !running || (act_per == '0) || (cnt == act_per - 1);
  assign apply_now   = pending && at_boundary;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running  <= 1'b0;
      pending  <= 1'b0;
      act_per  <= '0;
      act_duty <= '0;
      cnt      <= '0;
    end else begin
      if (launch_pulse) running <= 1'b1;
      if (commit_rise)    pending <= 1'b1;
      else if (apply_now) pending <= 1'b0;
      if (apply_now) begin
        act_per  <= stg_per;
        act_duty <= stg_act;
      end
      if (launch_pulse || apply_now)    cnt <= '0;
      else if (running && act_per != 0) cnt <= next_count(cnt, act_per);
    end
  end

  assign active = running && (act_per != '0) && in_active_phase(cnt, act_duty);
  assign pin    = pin_level(active, pol);
endmodule

// File: rtl/pwm6_bank.sv
module pwm6_bank
  import pwm6_pkg::*;
#(
  parameter int unsigned NCH    = 6,
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic [NCH-1:0]    pwm_out
);
  localparam int unsigned CH_W = ADDR_W - OFF_W;

  logic [CH_W-1:0]  ch_sel;
  logic [OFF_W-1:0] off_sel;
  assign ch_sel  = bus_addr[ADDR_W-1:OFF_W];
  assign off_sel = bus_addr[OFF_W-1:0];

  logic [NCH-1:0][WORD_W-1:0] ctrl_w, stg_per_w, stg_act_w;
  logic [NCH-1:0][WORD_W-1:0] act_per_w, act_duty_w, cnt_w;
  logic [NCH-1:0]             run_w, pend_w, pol_w;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic hit, launch, rise;
    assign hit = bus_we && (ch_sel == CH_W'(i));

    pwm6_chan_regs i_regs (
      .clk(clk), .rst_n(rst_n),
      .wr_ctrl(hit && off_sel == OFF_CTRL),
      .wr_per (hit && off_sel == OFF_PER),
      .wr_act (hit && off_sel == OFF_ACT),
      .wdata(bus_wdata),
      .ctrl_q(ctrl_w[i]), .stg_per(stg_per_w[i]), .stg_act(stg_act_w[i]),
      .launch_pulse(launch), .commit_rise(rise)
    );

    assign pol_w[i] = ctrl_w[i][B_POL];

    pwm6_chan_core i_core (
      .clk(clk), .rst_n(rst_n),
      .launch_pulse(launch), .commit_rise(rise),
      .stg_per(stg_per_w[i]), .stg_act(stg_act_w[i]), .pol(pol_w[i]),
      .pin(pwm_out[i]), .running(run_w[i]), .pending(pend_w[i]),
      .act_per(act_per_w[i]), .act_duty(act_duty_w[i]), .cnt(cnt_w[i])
    );
  end

  always_comb begin
    bus_rdata = '0;
    for (int i = 0; i < NCH; i++) begin
      if (ch_sel == CH_W'(i)) begin
        case (off_sel)
          OFF_CTRL: bus_rdata = ctrl_w[i];
          OFF_PER:  bus_rdata = stg_per_w[i];
          OFF_ACT:  bus_rdata = stg_act_w[i];
          default:  bus_rdata = '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/pwm6_bank_chk.sv
module pwm6_bank_chk
  import pwm6_pkg::*;
#(
  parameter int unsigned NCH    = 6,
  parameter int unsigned ADDR_W = 8
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic [ADDR_W-1:0]          bus_addr,
  input logic [31:0]                bus_rdata,
  input logic [NCH-1:0]             pwm_out,
  input logic [NCH-1:0]             pol_w,
  input logic [NCH-1:0]             run_w,
  input logic [NCH-1:0]             pend_w,
  input logic [NCH-1:0][WORD_W-1:0] act_per_w,
  input logic [NCH-1:0][WORD_W-1:0] act_duty_w,
  input logic [NCH-1:0][WORD_W-1:0] cnt_w
);
  assert_launch_reads_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr[OFF_W-1:0] == OFF_CTRL) |-> !bus_rdata[B_LAUNCH]);

  for (genvar i = 0; i < NCH; i++) begin : g_a
    assert_commit_needs_request_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (act_duty_w[i] != $past(act_duty_w[i])) |-> $past(pend_w[i]));

    assert_count_in_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (run_w[i] && act_per_w[i] != 0) |-> (cnt_w[i] < act_per_w[i]));

    assert_zero_period_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (act_per_w[i] == 0) |-> (pwm_out[i] == !pol_w[i]));

    assert_zero_duty_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (act_duty_w[i] == 0) |-> (pwm_out[i] == !pol_w[i]));

    assert_full_duty_active_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (run_w[i] && act_per_w[i] != 0 && act_duty_w[i] >= act_per_w[i])
        |-> (pwm_out[i] == pol_w[i]));

    assert_change_at_boundary_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (run_w[i] && $past(run_w[i]) && $past(act_per_w[i]) != 0
        && act_per_w[i] != $past(act_per_w[i]))
        |-> ($past(cnt_w[i]) == $past(act_per_w[i]) - 1 && cnt_w[i] == 0));
  end
endmodule

bind pwm6_bank pwm6_bank_chk #(.NCH(NCH), .ADDR_W(ADDR_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rdata(bus_rdata),
  .pwm_out(pwm_out), .pol_w(pol_w), .run_w(run_w), .pend_w(pend_w),
  .act_per_w(act_per_w), .act_duty_w(act_duty_w), .cnt_w(cnt_w)
);

// File: tb/test_pwm6_bank.sv
module test_pwm6_bank;
  localparam int NCH = 6;
  localparam logic [31:0] BASE = 32'h220;  // continuous + output enable
  localparam logic [31:0] POLB = 32'h100;
  localparam logic [31:0] COMMIT = 32'h4;
  localparam logic [31:0] LAUNCH = 32'h1;

  // per vector: period, active phase, polarity
  localparam int VEC [NCH][3] = '{
    '{4, 1, 1}, '{5, 3, 0}, '{7, 2, 1}, '{3, 3, 1}, '{6, 9, 0}, '{8, 5, 0}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [NCH-1:0] pwm_out;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  pwm6_bank i_pwm6_bank (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_out(pwm_out)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int ch, input int off, input logic [31:0] d);
    @(negedge clk);
    bus_addr = 8'(ch * 32 + off); bus_we = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input int ch, input int off, output logic [31:0] d);
    @(negedge clk);
    bus_addr = 8'(ch * 32 + off); bus_we = 1'b0;
    #1 d = bus_rdata;
  endtask

  task automatic count_high(input int ch, input int n, output int h);
    h = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (pwm_out[ch]) h++;
    end
  endtask

  task automatic setup(input int ch, input int per, input int act, input int pol, input bit go);
    logic [31:0] c;
    c = BASE | (pol != 0 ? POLB : 32'h0);
    wr(ch, 8, per);
    wr(ch, 12, act);
    wr(ch, 0, c);
    wr(ch, 0, c | COMMIT | (go ? LAUNCH : 32'h0));
  endtask

  initial begin
    #1_000_000;
    checks++; errors++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int h, run, bad, twos, first;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    @(negedge clk);
    chk(pwm_out == 6'h3f, "R1 outputs", pwm_out, 6'h3f);
    rd(0, 0, d);  chk(d == 0, "R1 ctrl0", d, 0);
    rd(5, 8, d);  chk(d == 0, "R1 per5", d, 0);
    rd(5, 12, d); chk(d == 0, "R1 act5", d, 0);

    // R3 control readback
    wr(4, 0, 32'hFFFF_FFFF);
    rd(4, 0, d); chk(d == 32'h324, "R3 mask", d, 32'h324);
    wr(4, 0, 32'h0000_0325);
    rd(4, 0, d); chk(d == 32'h324, "R3 launch reads 0", d, 32'h324);
    wr(4, 0, 32'h0);

    // R2 staged values readback at channel 5 window
    wr(5, 8, 32'h1234); wr(5, 12, 32'h56);
    rd(5, 8, d);  chk(d == 32'h1234, "R2 per", d, 32'h1234);
    rd(5, 12, d); chk(d == 32'h56, "R2 act", d, 32'h56);

    // R5 committed but not launched stays inactive, then launch runs
    setup(5, 4, 2, 1, 1'b0);
    repeat (10) @(negedge clk);
    count_high(5, 32, h); chk(h == 0, "R5 no launch", h, 0);
    wr(5, 0, BASE | POLB | COMMIT | LAUNCH);
    repeat (10) @(negedge clk);
    count_high(5, 32, h); chk(h == 16, "R5 launched", h, 16);

    // R6 / R9 vector table, one channel per vector
    for (int v = 0; v < NCH; v++) begin
      int p, a, e;
      p = VEC[v][0];
      a = (VEC[v][1] < p) ? VEC[v][1] : p;
      e = (VEC[v][2] != 0) ? a * 8 : (p - a) * 8;
      setup(v, VEC[v][0], VEC[v][1], VEC[v][2], 1'b1);
      repeat (2 * p + 4) @(negedge clk);
      count_high(v, 8 * p, h);
      chk(h == e, (VEC[v][1] >= p) ? "R9 table" : "R6 table", h, e);
    end

    // R4 repeated request ignored; clear-then-set takes effect (ch0: per 4, act 1, pol 1)
    wr(0, 12, 3);
    wr(0, 0, BASE | POLB | COMMIT);
    repeat (12) @(negedge clk);
    count_high(0, 32, h); chk(h == 8, "R4 no rise ignored", h, 8);
    wr(0, 0, BASE | POLB);
    wr(0, 0, BASE | POLB | COMMIT);
    repeat (12) @(negedge clk);
    count_high(0, 32, h); chk(h == 24, "R4 rise commits", h, 24);

    // R8 zero active phase turns running channel off
    wr(0, 12, 0);
    wr(0, 0, BASE | POLB);
    wr(0, 0, BASE | POLB | COMMIT);
    repeat (12) @(negedge clk);
    count_high(0, 32, h); chk(h == 0, "R8 off", h, 0);

    // R7 zero period: ch1 polarity 0 so inactive is high
    wr(1, 8, 0); wr(1, 12, 2);
    wr(1, 0, BASE);
    wr(1, 0, BASE | COMMIT);
    repeat (12) @(negedge clk);
    count_high(1, 40, h); chk(h == 40, "R7 zero period idle", h, 40);

    // R10 mid-period commit on ch2 (polarity 1)
    setup(2, 10, 5, 1, 1'b0);
    repeat (25) @(negedge clk);
    h = pwm_out[2];
    while (!(h == 0 && pwm_out[2] == 1'b1)) begin
      h = pwm_out[2];
      @(negedge clk);
    end
    run = 1; bad = 0; twos = 0; first = 0;
    fork
      begin
        for (int k = 0; k < 70; k++) begin
          @(negedge clk);
          if (pwm_out[2]) run++;
          else if (run > 0) begin
            if (first == 0) first = run;
            if (run == 2) twos++;
            else if (run != 5) bad++;
            run = 0;
          end
        end
      end
      begin
        repeat (2) @(negedge clk);
        wr(2, 8, 4); wr(2, 12, 2);
        wr(2, 0, BASE | POLB);
        wr(2, 0, BASE | POLB | COMMIT);
      end
    join
    chk(first == 5, "R10 old period completes", first, 5);
    chk(bad == 0, "R10 no partial run", bad, 0);
    chk(twos >= 5, "R10 new setting applied", twos, 5);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule